// File: doc/BRIEF.md
# DMA Channel Interrupt and Error Status Collector

This block gathers per-channel completion and fault events from a multi-channel DMA datapath and makes them visible to software through a small word-addressed register window. For every channel it keeps a completion flag, an interrupt mask bit and four separate fault flags. Each flag is sticky and is cleared by writing a one to it. It drives two interrupt lines. The first is a completion interrupt qualified by the mask. The second is an unmasked fault interrupt.

The datapath itself is not part of this block. It appears as one-cycle event pulses per channel, plus one level input per channel that is high while that channel's burst is stalled. A single programmable limit is shared by all channels. A per-channel stall counter compares against it and raises the burst-timeout flag when a stall lasts longer than the limit. A global control word enables event capture and issues a soft reset.

Top module: `dma_irq_status`

## Requirements
- R1: Registers sit at byte offsets 0x00 control, 0x04 completion status, 0x08 mask, 0x0C burst-timeout status, 0x10 request-timeout status, 0x14 transfer-error status, 0x18 buffer-overflow status and 0x1C burst-timeout control. Per-channel registers use bit n for channel n. Reading any other offset returns 0.
- R2: While control bit 0 is 1, a pulse on `done_evt[n]` sets bit n of 0x04 at the next clock edge. While control bit 0 is 0, every event input is ignored.
- R3: Writing 1 to a bit of 0x04, 0x0C, 0x10, 0x14 or 0x18 clears that bit. Writing 0 to a bit leaves it unchanged.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: A mask bit of 1 blocks that channel. `irq` is high exactly when some bit of 0x04 is set while its mask bit is 0.
- R6: Pulses on `req_tmo_evt`, `xfer_err_evt` and `buf_ovf_evt` set the channel's bit in 0x10, 0x14 and 0x18. `err_irq` is the OR of all four fault registers and ignores the mask.
- R7: In 0x1C, bit 15 enables burst timeout checking and bits 14:0 hold the limit L. Holding `burst_stall[n]` high for L+1 consecutive clock edges sets bit n of 0x0C. Holding it for only L edges, or holding it with bit 15 at 0, leaves the bit clear.
- R8: Control bit 0 is the enable and reads back as written. Writing 1 to control bit 1 is a soft reset that takes effect at that edge. It clears all five status registers, the enable and 0x1C, and sets all mask bits. Bit 1 always reads as 0.
- R9: After `rst_n` is low, control, 0x1C and all status registers read 0, the mask reads 0xFFFF, and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| done_evt | input | 16 | Per-channel completion pulses |
| req_tmo_evt | input | 16 | Per-channel request-timeout pulses |
| xfer_err_evt | input | 16 | Per-channel transfer-error pulses |
| buf_ovf_evt | input | 16 | Per-channel buffer-overflow pulses |
| burst_stall | input | 16 | Per-channel level, high while a burst is stalled |
| irq | output | 1 | Masked completion interrupt |
| err_irq | output | 1 | Fault interrupt |

## Verification
The two functions that can collide are hardware event capture and the software write-1 clear on the same flag bit. The bench provokes the collision by raising a completion pulse and a buffer-overflow pulse in exactly the cycle that software writes a one to the matching bit. It judges the outcome by reading the register afterwards, which must show the bit still set. A second collision is a soft reset landing while status bits are set. The bench checks it by reading back the cleared status registers and the restored all-ones mask.

// File: rtl/dma_irq_pkg.sv
// Package: shared sizes and the register offset map of the DMA status block.
// Assumes word-aligned byte offsets and no more than 32 channels.
package dma_irq_pkg;
    localparam int NUM_CH  = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int TMO_W   = 15;
    localparam int NBANK   = 5;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CTRL  = 6'h00,
        OFS_DONE  = 6'h04,
        OFS_MASK  = 6'h08,
        OFS_BTO   = 6'h0C,
        OFS_RTO   = 6'h10,
        OFS_XERR  = 6'h14,
        OFS_BOVF  = 6'h18,
        OFS_BTCTL = 6'h1C
    } reg_ofs_e;

    // Bank index: 0 done, 1 burst timeout, 2 request timeout, 3 transfer error, 4 overflow
    function automatic logic [ADDR_W-1:0] bank_ofs(input int k);
        case (k)
            0:       return OFS_DONE;
            1:       return OFS_BTO;
            2:       return OFS_RTO;
            3:       return OFS_XERR;
            default: return OFS_BOVF;
        endcase
    endfunction
endpackage

// File: rtl/dma_w1c_bank.sv
// Module: one sticky per-channel status register.
// An event sets a bit, a write-1 clears it, and an event beats a clear in the same cycle.
// Assumes events arrive as single-cycle pulses; sclr is a synchronous soft clear.
module dma_w1c_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclr,
    input  logic         en,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] evt_g;

    // Gate events with the module enable
    always_comb evt_g = en ? evt : '0;

    // Hold, clear on write-1, set on event
    always_ff @(posedge clk) begin
        if (!rst_n || sclr) q <= '0;
        else                q <= (q & ~clr) | evt_g;
    end

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        !sclr |=> ((q & $past(evt_g)) == $past(evt_g)));  // R4

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclr && clr != '0) |=> ((q & $past(clr) & ~$past(evt_g)) == '0));  // R3

    AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sclr |=> ((q & ($past(q) & ~$past(clr))) == ($past(q) & ~$past(clr))));  // R3
endmodule

// File: rtl/dma_burst_watch.sv
// Module: per-channel burst stall counters against one shared limit.
// Raises a one-cycle hit when a channel's stall outlasts the limit, once per stall episode.
// Assumes burst_stall is a level; counters restart whenever the stall drops or checking is off.
module dma_burst_watch #(
    parameter int NCH   = 16,
    parameter int TMO_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclr,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    input  logic [NCH-1:0]   stall,
    output logic [NCH-1:0]   hit
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [TMO_W-1:0] cnt;
        logic             fired;

        // Hit when the stall is still present after the limit was reached
        always_comb hit[c] = run && stall[c] && (cnt == limit) && !fired;

        // Count consecutive stalled cycles, latch that this episode has fired
        always_ff @(posedge clk) begin
            if (!rst_n || sclr || !run || !stall[c]) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else if (cnt == limit) begin
                fired <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end

        AST_TMO_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |=> !hit[c]);  // R7
    end
endmodule

// File: rtl/dma_irq_status.sv
// Module: top of the DMA interrupt and error status block.
// Decodes the register window, holds control, mask and burst-timeout settings,
// and drives the completion and fault interrupts from the status banks.
// Assumes a single-cycle write strobe and combinational read data.
module dma_irq_status
    import dma_irq_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    done_evt,
    input  logic [NCH-1:0]    req_tmo_evt,
    input  logic [NCH-1:0]    xfer_err_evt,
    input  logic [NCH-1:0]    buf_ovf_evt,
    input  logic [NCH-1:0]    burst_stall,
    output logic              irq,
    output logic              err_irq
);
    localparam int PAD = DATA_W - NCH;

    logic             ctrl_en;
    logic             bt_en;
    logic [TMO_W-1:0] bt_lim;
    logic [NCH-1:0]   mask_q;
    logic             soft_rst;
    logic [NCH-1:0]   bto_hit;
    logic [NCH-1:0]   bank_evt [NBANK];
    logic [NCH-1:0]   bank_clr [NBANK];
    logic [NCH-1:0]   bank_q   [NBANK];

    // Soft reset request from control bit 1
    always_comb soft_rst = reg_wr_en && (reg_addr == OFS_CTRL) && reg_wdata[1];

    // Route each event source to its bank
    always_comb begin
        bank_evt[0] = done_evt;
        bank_evt[1] = bto_hit;
        bank_evt[2] = req_tmo_evt;
        bank_evt[3] = xfer_err_evt;
        bank_evt[4] = buf_ovf_evt;
    end

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        // Write-1 clear mask for this bank
        always_comb bank_clr[k] = (reg_wr_en && reg_addr == bank_ofs(k)) ?
                                  reg_wdata[NCH-1:0] : '0;

        dma_w1c_bank #(.W(NCH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sclr  (soft_rst),
            .en    (ctrl_en),
            .evt   (bank_evt[k]),
            .clr   (bank_clr[k]),
            .q     (bank_q[k])
        );
    end

    dma_burst_watch #(.NCH(NCH), .TMO_W(TMO_W)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .sclr  (soft_rst),
        .run   (ctrl_en && bt_en),
        .limit (bt_lim),
        .stall (burst_stall),
        .hit   (bto_hit)
    );

    // Control, mask and burst-timeout settings
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_en <= 1'b0;
            bt_en   <= 1'b0;
            bt_lim  <= '0;
            mask_q  <= '1;
        end else if (reg_wr_en) begin
            case (reg_addr)
                OFS_CTRL:  ctrl_en <= reg_wdata[0];
                OFS_MASK:  mask_q  <= reg_wdata[NCH-1:0];
                OFS_BTCTL: begin
                    bt_en  <= reg_wdata[15];
                    bt_lim <= reg_wdata[TMO_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // Read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL:  reg_rdata = {{(DATA_W-1){1'b0}}, ctrl_en};
            OFS_DONE:  reg_rdata = {{PAD{1'b0}}, bank_q[0]};
            OFS_MASK:  reg_rdata = {{PAD{1'b0}}, mask_q};
            OFS_BTO:   reg_rdata = {{PAD{1'b0}}, bank_q[1]};
            OFS_RTO:   reg_rdata = {{PAD{1'b0}}, bank_q[2]};
            OFS_XERR:  reg_rdata = {{PAD{1'b0}}, bank_q[3]};
            OFS_BOVF:  reg_rdata = {{PAD{1'b0}}, bank_q[4]};
            OFS_BTCTL: reg_rdata = {{(DATA_W-16){1'b0}}, bt_en, bt_lim};
            default:   reg_rdata = '0;
        endcase
    end

    // Interrupt outputs
    always_comb begin
        irq     = |(bank_q[0] & ~mask_q);
        err_irq = |(bank_q[1] | bank_q[2] | bank_q[3] | bank_q[4]);
    end

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mask_q == '1 && !irq && !err_irq && !ctrl_en));  // R8

    AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);  // R5

    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !reg_wr_en) |=> err_irq);  // R6
endmodule

// File: tb/dma_irq_status_bench.sv
// Scoreboard bench: driver tasks queue expected values, a monitor pops and compares.
module dma_irq_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] done_evt = '0, req_tmo_evt = '0, xfer_err_evt = '0, buf_ovf_evt = '0;
    logic [15:0] burst_stall = '0;
    logic        irq, err_irq;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        int          kind;   // 0 register, 1 irq, 2 err_irq
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    event obs_ev;
    bit   done_flag = 0;

    always #4 clk = ~clk;

    dma_irq_status u_dma_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_evt(done_evt),
        .req_tmo_evt(req_tmo_evt), .xfer_err_evt(xfer_err_evt),
        .buf_ovf_evt(buf_ovf_evt), .burst_stall(burst_stall),
        .irq(irq), .err_irq(err_irq)
    );

    // Monitor: pop expected items and compare against the outputs
    initial begin
        forever begin
            @(obs_ev);
            while (sbq.size() > 0) begin
                exp_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                act = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, err_irq};
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic chk_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        reg_addr = a;
        #1;
        it.kind = 0; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        -> obs_ev;
        #1;
    endtask

    task automatic chk_pin(input int k, input logic e, input string tag);
        exp_t it;
        #1;
        it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
        sbq.push_back(it);
        -> obs_ev;
        #1;
    endtask

    task automatic pulse(input logic [15:0] d, input logic [15:0] r,
                         input logic [15:0] x, input logic [15:0] b);
        @(negedge clk);
        done_evt = d; req_tmo_evt = r; xfer_err_evt = x; buf_ovf_evt = b;
        @(negedge clk);
        done_evt = '0; req_tmo_evt = '0; xfer_err_evt = '0; buf_ovf_evt = '0;
    endtask

    task automatic stall(input int ch, input int edges);
        @(negedge clk);
        burst_stall[ch] = 1'b1;
        repeat (edges) @(negedge clk);
        burst_stall[ch] = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk_reg(6'h00, 32'h0, "R9 ctrl");
        chk_reg(6'h04, 32'h0, "R9 done");
        chk_reg(6'h08, 32'hFFFF, "R9 mask");
        chk_reg(6'h0C, 32'h0, "R9 bto");
        chk_reg(6'h1C, 32'h0, "R9 btctl");
        chk_pin(1, 1'b0, "R9 irq");
        chk_pin(2, 1'b0, "R9 err_irq");
        // R2 events ignored while disabled
        pulse(16'h0001, 16'h0002, 16'h0, 16'h0);
        chk_reg(6'h04, 32'h0, "R2 disabled done");
        chk_reg(6'h10, 32'h0, "R2 disabled rto");
        // R8 enable reads back, R1 unmapped reads 0
        wr(6'h00, 32'h1);
        chk_reg(6'h00, 32'h1, "R8 enable");
        chk_reg(6'h20, 32'h0, "R1 unmapped");
        // R2 capture, R5 mask
        pulse(16'h8001, 16'h0, 16'h0, 16'h0);
        chk_reg(6'h04, 32'h8001, "R2 done capture");
        chk_pin(1, 1'b0, "R5 all masked");
        wr(6'h08, 32'hFFFE);
        chk_reg(6'h08, 32'hFFFE, "R1 mask readback");
        chk_pin(1, 1'b1, "R5 unmasked irq");
        // R3 write-1 clear and write-0 no effect
        wr(6'h04, 32'h8000);
        chk_reg(6'h04, 32'h0001, "R3 w1c");
        wr(6'h04, 32'h0);
        chk_reg(6'h04, 32'h0001, "R3 w0 no effect");
        // R4 event and clear in the same cycle
        @(negedge clk);
        done_evt = 16'h0001; reg_wr_en = 1'b1; reg_addr = 6'h04; reg_wdata = 32'h1;
        @(negedge clk);
        done_evt = '0; reg_wr_en = 1'b0;
        chk_reg(6'h04, 32'h0001, "R4 event wins");
        wr(6'h04, 32'h1);
        chk_reg(6'h04, 32'h0, "R3 cleared");
        chk_pin(1, 1'b0, "R5 irq drops");
        // R6 fault registers and fault interrupt ignore mask
        wr(6'h08, 32'hFFFF);
        pulse(16'h0, 16'h0010, 16'h0100, 16'h2000);
        chk_reg(6'h10, 32'h0010, "R6 rto");
        chk_reg(6'h14, 32'h0100, "R6 xerr");
        chk_reg(6'h18, 32'h2000, "R6 bovf");
        chk_pin(2, 1'b1, "R6 err_irq");
        wr(6'h10, 32'hFFFF);
        wr(6'h14, 32'hFFFF);
        chk_pin(2, 1'b1, "R6 err_irq still");
        @(negedge clk);
        buf_ovf_evt = 16'h2000; reg_wr_en = 1'b1; reg_addr = 6'h18; reg_wdata = 32'h2000;
        @(negedge clk);
        buf_ovf_evt = '0; reg_wr_en = 1'b0;
        chk_reg(6'h18, 32'h2000, "R4 bovf event wins");
        wr(6'h18, 32'h2000);
        chk_pin(2, 1'b0, "R6 err_irq clear");
        // R7 burst timeout
        stall(1, 10);
        chk_reg(6'h0C, 32'h0, "R7 disabled");
        wr(6'h1C, 32'h8003);
        chk_reg(6'h1C, 32'h8003, "R7 btctl readback");
        stall(5, 3);
        chk_reg(6'h0C, 32'h0, "R7 exactly limit");
        stall(2, 4);
        chk_reg(6'h0C, 32'h0004, "R7 over limit");
        chk_pin(2, 1'b1, "R7 err_irq");
        // R8 soft reset
        pulse(16'h00F0, 16'h0001, 16'h0, 16'h0);
        wr(6'h08, 32'h0);
        wr(6'h00, 32'h3);
        chk_reg(6'h00, 32'h0, "R8 ctrl cleared");
        chk_reg(6'h04, 32'h0, "R8 done cleared");
        chk_reg(6'h0C, 32'h0, "R8 bto cleared");
        chk_reg(6'h10, 32'h0, "R8 rto cleared");
        chk_reg(6'h08, 32'hFFFF, "R8 mask set");
        chk_reg(6'h1C, 32'h0, "R8 btctl cleared");
        chk_pin(1, 1'b0, "R8 irq low");
        chk_pin(2, 1'b0, "R8 err_irq low");
        done_flag = 1;
        #2;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule